// File: doc/BRIEF.md
# Write-Through L1 Line Controller

This block governs one line of a GPU first-level data cache that never holds dirty data. Requests arrive from the core side over a valid/ready port: load, store, atomic, flush and evict. Responses arrive from the next cache level: line fills, atomic results and write acknowledgements. In return the controller sends read-block, write-through and atomic requests downstream. Toward the core it pulses load-done, store-done, atomic-done and write-complete. Every store is written through at once, so a flush never moves data.

The line is in one of three states: Invalid, Valid (read-only) or Atomic-pending. While an atomic is outstanding, new loads, stores and atomics to the line are held at the port by dropping ready. Bytes written while the line is not valid are kept under a per-byte mask, so that a later fill cannot overwrite them. The instruction sequence number rides along with each downstream write or atomic. It comes back with the acknowledgement and is reported with the completion.

Top module: `wtl1_line_ctrl`

## Requirements
- R1: After reset the line is Invalid with an empty byte mask, and every upstream strobe, `dn_valid` and `flush_flag` are low. In this state `req_ready` is high.
- R2: A load accepted in Valid pulses `load_done` one cycle later, with the line contents on `load_data` and no downstream request. A load accepted in Invalid sends `dn_op`=1 (read-block) with the request's sequence number, and nothing goes upstream.
- R3: A fill response (`rsp_type`=0) outside Atomic-pending makes the line Valid and clears the mask. One cycle later it pulses `load_done` carrying the merged line: a byte whose mask bit is set keeps its stored value, and every other byte takes the fill byte.
- R4: An accepted store always pulses `store_done` and sends `dn_op`=2 (write-through) one cycle later, carrying the request's data, mask and sequence number. It writes the bytes whose mask bits are set into the line and ORs its mask into the pending mask. A store accepted in Invalid leaves the line Invalid.
- R5: A store accepted in Valid moves the line to Invalid, so the next load issues a read-block.
- R6: An accepted atomic sends `dn_op`=3 with the request's data, mask and sequence number one cycle later. It records that sequence number and moves the line to Atomic-pending.
- R7: In Atomic-pending, `req_ready` is low for load (`req_op`=0), store (1) and atomic (2), and the held request has no effect. Flush and evict are still accepted.
- R8: An atomic response (`rsp_type`=1) in Atomic-pending writes the returned data into the line, clears the mask and makes the line Invalid. One cycle later it pulses `atomic_done` with that data and the recorded sequence number. An atomic response in any other state is ignored.
- R9: A flush (`req_op`=3) pulses `flush_flag` one cycle later. It changes neither the line state nor the contents, and sends nothing downstream.
- R10: An evict (`req_op`=4) in Valid or Invalid makes the line Invalid and clears the mask. In Atomic-pending it changes nothing.
- R11: A write acknowledgement (`rsp_type`=2) in any state pulses `write_done` one cycle later, with `write_seq` equal to the response's sequence number. It does not block a request in the same cycle.
- R12: While a fill or atomic response is valid, `req_ready` is low, and at most one of `load_done`, `store_done` and `atomic_done` is high in any cycle.
- R13: Request codes 5 to 7 are accepted and have no effect. Response code 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_op | input | 3 | 0 load, 1 store, 2 atomic, 3 flush, 4 evict |
| req_data | input | LINE_BYTES*8 | Store or atomic operand data |
| req_mask | input | LINE_BYTES | Byte mask of the request |
| req_seq | input | SEQ_W | Instruction sequence number |
| rsp_valid | input | 1 | Lower-level response valid |
| rsp_type | input | 2 | 0 fill, 1 atomic result, 2 write acknowledge |
| rsp_data | input | LINE_BYTES*8 | Fill or atomic result data |
| rsp_seq | input | SEQ_W | Sequence number of an acknowledged write |
| dn_valid | output | 1 | Downstream request strobe |
| dn_op | output | 2 | 1 read-block, 2 write-through, 3 atomic |
| dn_data | output | LINE_BYTES*8 | Write or atomic data, zero for read-block |
| dn_mask | output | LINE_BYTES | Write or atomic byte mask, zero for read-block |
| dn_seq | output | SEQ_W | Sequence number of the downstream request |
| load_done | output | 1 | Load completion strobe |
| load_data | output | LINE_BYTES*8 | Load result, zero when no strobe |
| store_done | output | 1 | Store completion strobe |
| atomic_done | output | 1 | Atomic completion strobe |
| atomic_data | output | LINE_BYTES*8 | Atomic result, zero when no strobe |
| atomic_seq | output | SEQ_W | Sequence number of the completed atomic |
| write_done | output | 1 | Write-through completion strobe |
| write_seq | output | SEQ_W | Sequence number of the completed write |
| flush_flag | output | 1 | Flush seen strobe |

## Verification
On every cycle the assertions check several fixed links between accepted inputs and the next cycle's outputs. They cover the downstream fields of stores and atomics, the fact that a load held in Atomic-pending produces nothing, and the acknowledgement-to-write-complete path with its sequence number. They also cover the state left behind by a store to a Valid line and by an evict during Atomic-pending, and the exclusivity of the upstream strobes. Only the bench's scenarios can show that data holds up over a sequence of operations. That includes a fill preserving bytes stored earlier under an accumulated mask, a held load resuming after the atomic returns, and an atomic result or unused code arriving outside its state leaving the line untouched.

// File: rtl/wtl1_pkg.sv
package wtl1_pkg;

    typedef enum logic [1:0] {
        ST_INV  = 2'd0,
        ST_VAL  = 2'd1,
        ST_ATOM = 2'd2
    } state_e;

    typedef enum logic [2:0] {
        OP_LOAD   = 3'd0,
        OP_STORE  = 3'd1,
        OP_ATOMIC = 3'd2,
        OP_FLUSH  = 3'd3,
        OP_EVICT  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        RSP_FILL = 2'd0,
        RSP_ATOM = 2'd1,
        RSP_WACK = 2'd2
    } rsp_e;

    typedef enum logic [1:0] {
        DN_NONE  = 2'd0,
        DN_READ  = 2'd1,
        DN_WRITE = 2'd2,
        DN_ATOM  = 2'd3
    } dn_e;

    typedef enum logic [1:0] {
        WR_NONE  = 2'd0,
        WR_STORE = 2'd1,
        WR_FILL  = 2'd2,
        WR_ATOM  = 2'd3
    } wr_e;

    typedef struct packed {
        state_e nxt;
        wr_e    wr;
        logic   mask_clr;
        dn_e    dn;
        logic   ld_done;
        logic   ld_fill;
        logic   st_done;
        logic   at_done;
        logic   fl;
        logic   wd;
    } act_t;

    function automatic logic touches_line(input op_e op);
        return (op == OP_LOAD) || (op == OP_STORE) || (op == OP_ATOMIC);
    endfunction

    function automatic logic is_line_rsp(input logic v, input logic [1:0] t);
        return v && ((t == RSP_FILL) || (t == RSP_ATOM));
    endfunction

endpackage

// File: rtl/wtl1_decode.sv
module wtl1_decode
    import wtl1_pkg::*;
(
    input  state_e      state_q,
    input  logic        req_valid,
    input  logic [2:0]  req_op,
    input  logic        rsp_valid,
    input  logic [1:0]  rsp_type,
    output logic        req_ready,
    output act_t        act
);

    op_e  op;
    logic fire;

    assign op        = op_e'(req_op);
    assign req_ready = !is_line_rsp(rsp_valid, rsp_type) &&
                       !((state_q == ST_ATOM) && touches_line(op));
    assign fire      = req_valid && req_ready;

    always_comb begin
        act          = '0;
        act.nxt      = state_q;
        act.wr       = WR_NONE;
        act.dn       = DN_NONE;

        if (rsp_valid) begin
            case (rsp_type)
                RSP_FILL: begin
                    if (state_q != ST_ATOM) begin
                        act.wr       = WR_FILL;
                        act.nxt      = ST_VAL;
                        act.mask_clr = 1'b1;
                        act.ld_done  = 1'b1;
                        act.ld_fill  = 1'b1;
                    end
                end
                RSP_ATOM: begin
                    if (state_q == ST_ATOM) begin
                        act.wr       = WR_ATOM;
                        act.nxt      = ST_INV;
                        act.mask_clr = 1'b1;
                        act.at_done  = 1'b1;
                    end
                end
                RSP_WACK: act.wd = 1'b1;
                default: ;
            endcase
        end

        if (fire) begin
            case (op)
                OP_LOAD: begin
                    if (state_q == ST_VAL) act.ld_done = 1'b1;
                    else                   act.dn      = DN_READ;
                end
                OP_STORE: begin
                    act.wr      = WR_STORE;
                    act.st_done = 1'b1;
                    act.dn      = DN_WRITE;
                    if (state_q == ST_VAL) act.nxt = ST_INV;
                end
                OP_ATOMIC: begin
                    act.dn  = DN_ATOM;
                    act.nxt = ST_ATOM;
                end
                OP_FLUSH: act.fl = 1'b1;
                OP_EVICT: begin
                    if (state_q != ST_ATOM) begin
                        act.nxt      = ST_INV;
                        act.mask_clr = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/wtl1_line.sv
module wtl1_line
    import wtl1_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int SEQ_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  state_e                  nxt,
    input  wr_e                     wr,
    input  logic                    mask_clr,
    input  logic                    tbe_load,
    input  logic [LINE_BYTES*8-1:0] req_data,
    input  logic [LINE_BYTES-1:0]   req_mask,
    input  logic [SEQ_W-1:0]        req_seq,
    input  logic [LINE_BYTES*8-1:0] rsp_data,
    output state_e                  state_q,
    output logic [LINE_BYTES*8-1:0] data_q,
    output logic [LINE_BYTES*8-1:0] fill_merged,
    output logic [SEQ_W-1:0]        tbe_seq_q
);

    localparam int DATA_W = LINE_BYTES * 8;

    logic [DATA_W-1:0]     data_n;
    logic [LINE_BYTES-1:0] mask_q;
    logic [LINE_BYTES-1:0] mask_n;

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
        logic [7:0] old_b;
        logic [7:0] req_b;
        logic [7:0] rsp_b;
        logic [7:0] fill_b;
        logic [7:0] new_b;

        assign old_b = data_q[b*8 +: 8];
        assign req_b = req_data[b*8 +: 8];
        assign rsp_b = rsp_data[b*8 +: 8];

        always_comb begin
            fill_b = mask_q[b] ? old_b : rsp_b;
            case (wr)
                WR_STORE: new_b = req_mask[b] ? req_b : old_b;
                WR_FILL:  new_b = fill_b;
                WR_ATOM:  new_b = rsp_b;
                default:  new_b = old_b;
            endcase
        end

        assign data_n[b*8 +: 8]      = new_b;
        assign fill_merged[b*8 +: 8] = fill_b;
    end

    always_comb begin
        if (mask_clr)             mask_n = '0;
        else if (wr == WR_STORE)  mask_n = mask_q | req_mask;
        else                      mask_n = mask_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_INV;
            data_q    <= '0;
            mask_q    <= '0;
            tbe_seq_q <= '0;
        end else begin
            state_q <= nxt;
            data_q  <= data_n;
            mask_q  <= mask_n;
            if (tbe_load) tbe_seq_q <= req_seq;
        end
    end

endmodule

// File: rtl/wtl1_outreg.sv
module wtl1_outreg
    import wtl1_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int SEQ_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  dn_e                     dn,
    input  logic                    ld_done,
    input  logic                    ld_fill,
    input  logic                    st_done,
    input  logic                    at_done,
    input  logic                    fl,
    input  logic                    wd,
    input  logic [LINE_BYTES*8-1:0] req_data,
    input  logic [LINE_BYTES-1:0]   req_mask,
    input  logic [SEQ_W-1:0]        req_seq,
    input  logic [LINE_BYTES*8-1:0] rsp_data,
    input  logic [SEQ_W-1:0]        rsp_seq,
    input  logic [LINE_BYTES*8-1:0] line_data,
    input  logic [LINE_BYTES*8-1:0] fill_merged,
    input  logic [SEQ_W-1:0]        tbe_seq,
    output logic                    dn_valid,
    output logic [1:0]              dn_op,
    output logic [LINE_BYTES*8-1:0] dn_data,
    output logic [LINE_BYTES-1:0]   dn_mask,
    output logic [SEQ_W-1:0]        dn_seq,
    output logic                    load_done,
    output logic [LINE_BYTES*8-1:0] load_data,
    output logic                    store_done,
    output logic                    atomic_done,
    output logic [LINE_BYTES*8-1:0] atomic_data,
    output logic [SEQ_W-1:0]        atomic_seq,
    output logic                    write_done,
    output logic [SEQ_W-1:0]        write_seq,
    output logic                    flush_flag
);

    logic carries_data;
    assign carries_data = (dn == DN_WRITE) || (dn == DN_ATOM);

    always_ff @(posedge clk) begin
        if (rst) begin
            dn_valid    <= 1'b0;
            dn_op       <= DN_NONE;
            dn_data     <= '0;
            dn_mask     <= '0;
            dn_seq      <= '0;
            load_done   <= 1'b0;
            load_data   <= '0;
            store_done  <= 1'b0;
            atomic_done <= 1'b0;
            atomic_data <= '0;
            atomic_seq  <= '0;
            write_done  <= 1'b0;
            write_seq   <= '0;
            flush_flag  <= 1'b0;
        end else begin
            dn_valid    <= (dn != DN_NONE);
            dn_op       <= dn;
            dn_data     <= carries_data ? req_data : '0;
            dn_mask     <= carries_data ? req_mask : '0;
            dn_seq      <= (dn != DN_NONE) ? req_seq : '0;
            load_done   <= ld_done;
            load_data   <= !ld_done ? '0 : (ld_fill ? fill_merged : line_data);
            store_done  <= st_done;
            atomic_done <= at_done;
            atomic_data <= at_done ? rsp_data : '0;
            atomic_seq  <= at_done ? tbe_seq : '0;
            write_done  <= wd;
            write_seq   <= wd ? rsp_seq : '0;
            flush_flag  <= fl;
        end
    end

endmodule

// File: rtl/wtl1_line_ctrl.sv
module wtl1_line_ctrl
    import wtl1_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int SEQ_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [2:0]              req_op,
    input  logic [LINE_BYTES*8-1:0] req_data,
    input  logic [LINE_BYTES-1:0]   req_mask,
    input  logic [SEQ_W-1:0]        req_seq,
    input  logic                    rsp_valid,
    input  logic [1:0]              rsp_type,
    input  logic [LINE_BYTES*8-1:0] rsp_data,
    input  logic [SEQ_W-1:0]        rsp_seq,
    output logic                    dn_valid,
    output logic [1:0]              dn_op,
    output logic [LINE_BYTES*8-1:0] dn_data,
    output logic [LINE_BYTES-1:0]   dn_mask,
    output logic [SEQ_W-1:0]        dn_seq,
    output logic                    load_done,
    output logic [LINE_BYTES*8-1:0] load_data,
    output logic                    store_done,
    output logic                    atomic_done,
    output logic [LINE_BYTES*8-1:0] atomic_data,
    output logic [SEQ_W-1:0]        atomic_seq,
    output logic                    write_done,
    output logic [SEQ_W-1:0]        write_seq,
    output logic                    flush_flag
);

    localparam int DATA_W = LINE_BYTES * 8;

    state_e            state_q;
    act_t              act;
    logic [DATA_W-1:0] line_data;
    logic [DATA_W-1:0] fill_merged;
    logic [SEQ_W-1:0]  tbe_seq;

    wtl1_decode u_decode (
        .state_q   (state_q),
        .req_valid (req_valid),
        .req_op    (req_op),
        .rsp_valid (rsp_valid),
        .rsp_type  (rsp_type),
        .req_ready (req_ready),
        .act       (act)
    );

    wtl1_line #(
        .LINE_BYTES (LINE_BYTES),
        .SEQ_W      (SEQ_W)
    ) u_line (
        .clk         (clk),
        .rst         (rst),
        .nxt         (act.nxt),
        .wr          (act.wr),
        .mask_clr    (act.mask_clr),
        .tbe_load    (act.dn == DN_ATOM),
        .req_data    (req_data),
        .req_mask    (req_mask),
        .req_seq     (req_seq),
        .rsp_data    (rsp_data),
        .state_q     (state_q),
        .data_q      (line_data),
        .fill_merged (fill_merged),
        .tbe_seq_q   (tbe_seq)
    );

    wtl1_outreg #(
        .LINE_BYTES (LINE_BYTES),
        .SEQ_W      (SEQ_W)
    ) u_out (
        .clk         (clk),
        .rst         (rst),
        .dn          (act.dn),
        .ld_done     (act.ld_done),
        .ld_fill     (act.ld_fill),
        .st_done     (act.st_done),
        .at_done     (act.at_done),
        .fl          (act.fl),
        .wd          (act.wd),
        .req_data    (req_data),
        .req_mask    (req_mask),
        .req_seq     (req_seq),
        .rsp_data    (rsp_data),
        .rsp_seq     (rsp_seq),
        .line_data   (line_data),
        .fill_merged (fill_merged),
        .tbe_seq     (tbe_seq),
        .dn_valid    (dn_valid),
        .dn_op       (dn_op),
        .dn_data     (dn_data),
        .dn_mask     (dn_mask),
        .dn_seq      (dn_seq),
        .load_done   (load_done),
        .load_data   (load_data),
        .store_done  (store_done),
        .atomic_done (atomic_done),
        .atomic_data (atomic_data),
        .atomic_seq  (atomic_seq),
        .write_done  (write_done),
        .write_seq   (write_seq),
        .flush_flag  (flush_flag)
    );

endmodule

// File: rtl/wtl1_checker.sv
module wtl1_checker
    import wtl1_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int SEQ_W      = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic [2:0]              req_op,
    input logic [LINE_BYTES*8-1:0] req_data,
    input logic [LINE_BYTES-1:0]   req_mask,
    input logic [SEQ_W-1:0]        req_seq,
    input logic                    rsp_valid,
    input logic [1:0]              rsp_type,
    input logic [LINE_BYTES*8-1:0] rsp_data,
    input logic [SEQ_W-1:0]        rsp_seq,
    input logic                    dn_valid,
    input logic [1:0]              dn_op,
    input logic [LINE_BYTES*8-1:0] dn_data,
    input logic [LINE_BYTES-1:0]   dn_mask,
    input logic [SEQ_W-1:0]        dn_seq,
    input logic                    load_done,
    input logic                    store_done,
    input logic                    atomic_done,
    input logic [LINE_BYTES*8-1:0] atomic_data,
    input logic                    write_done,
    input logic [SEQ_W-1:0]        write_seq,
    input logic                    flush_flag,
    input state_e                  state_q
);

    // R4: accepted store goes out as a write-through with its own fields
    assert_store_wt_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_op == 3'd1) |=>
        (store_done && dn_valid && dn_op == 2'd2 &&
         dn_data == $past(req_data) && dn_mask == $past(req_mask) &&
         dn_seq == $past(req_seq)));

    // R5: store to a valid line leaves it invalid
    assert_store_inval_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_VAL && req_valid && req_ready && req_op == 3'd1) |=>
        (state_q == ST_INV));

    // R6: accepted atomic goes downstream and parks the line
    assert_atomic_issue_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_op == 3'd2) |=>
        (dn_valid && dn_op == 2'd3 && dn_seq == $past(req_seq) &&
         state_q == ST_ATOM));

    // R7: a load held in atomic-pending produces nothing
    assert_stall_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ATOM && req_valid && req_op == 3'd0) |=>
        (!load_done && !dn_valid));

    // R8: atomic result in atomic-pending is returned upstream
    assert_atomic_ret_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ATOM && rsp_valid && rsp_type == 2'd1) |=>
        (atomic_done && atomic_data == $past(rsp_data) && state_q == ST_INV));

    // R9: flush raises only the flag
    assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_op == 3'd3) |=>
        (flush_flag && !dn_valid && $stable(state_q)));

    // R10: evict during atomic-pending keeps the state
    assert_evict_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ATOM && req_valid && req_ready && req_op == 3'd4) |=>
        (state_q == ST_ATOM));

    // R11: write acknowledge becomes write-complete with its number
    assert_wack_R11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_type == 2'd2) |=>
        (write_done && write_seq == $past(rsp_seq)));

    // R12: upstream completion strobes never coincide
    assert_excl_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({load_done, store_done, atomic_done}));

endmodule

bind wtl1_line_ctrl wtl1_checker #(
    .LINE_BYTES (LINE_BYTES),
    .SEQ_W      (SEQ_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_op      (req_op),
    .req_data    (req_data),
    .req_mask    (req_mask),
    .req_seq     (req_seq),
    .rsp_valid   (rsp_valid),
    .rsp_type    (rsp_type),
    .rsp_data    (rsp_data),
    .rsp_seq     (rsp_seq),
    .dn_valid    (dn_valid),
    .dn_op       (dn_op),
    .dn_data     (dn_data),
    .dn_mask     (dn_mask),
    .dn_seq      (dn_seq),
    .load_done   (load_done),
    .store_done  (store_done),
    .atomic_done (atomic_done),
    .atomic_data (atomic_data),
    .write_done  (write_done),
    .write_seq   (write_seq),
    .flush_flag  (flush_flag),
    .state_q     (state_q)
);

// File: tb/wtl1_line_ctrl_tb.sv
module wtl1_line_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 64;
    localparam int DW = NB * 8;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = '0;
    logic [DW-1:0] req_data = '0;
    logic [NB-1:0] req_mask = '0;
    logic [SW-1:0] req_seq = '0;
    logic          rsp_valid = 1'b0;
    logic [1:0]    rsp_type = '0;
    logic [DW-1:0] rsp_data = '0;
    logic [SW-1:0] rsp_seq = '0;
    logic          dn_valid;
    logic [1:0]    dn_op;
    logic [DW-1:0] dn_data;
    logic [NB-1:0] dn_mask;
    logic [SW-1:0] dn_seq;
    logic          load_done;
    logic [DW-1:0] load_data;
    logic          store_done;
    logic          atomic_done;
    logic [DW-1:0] atomic_data;
    logic [SW-1:0] atomic_seq;
    logic          write_done;
    logic [SW-1:0] write_seq;
    logic          flush_flag;

    wtl1_line_ctrl #(.LINE_BYTES(NB), .SEQ_W(SW)) u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    // reference model
    int            m_st = 0;   // 0 invalid, 1 valid, 2 atomic-pending
    logic [DW-1:0] m_data = '0;
    logic [NB-1:0] m_mask = '0;
    logic [SW-1:0] m_tbe = '0;
    logic          e_dnv = 0, e_ld = 0, e_st = 0, e_at = 0, e_wd = 0, e_fl = 0;
    logic [1:0]    e_dop = 0;
    logic [DW-1:0] e_dd = 0, e_ldd = 0, e_atd = 0;
    logic [NB-1:0] e_dm = 0;
    logic [SW-1:0] e_ds = 0, e_ats = 0, e_ws = 0;
    string         prev_tag = "R1";

    task automatic cmp(string tag, string nm, logic [DW-1:0] a, logic [DW-1:0] e);
        n_checks++;
        if (a !== e) begin
            n_err++;
            $display("FAIL %s %s actual %h expected %h", tag, nm, a, e);
        end
    endtask

    task automatic compare_all(string tag);
        cmp(tag, "dn_valid", DW'(dn_valid), DW'(e_dnv));
        cmp(tag, "dn_op", DW'(dn_op), DW'(e_dop));
        cmp(tag, "dn_data", dn_data, e_dd);
        cmp(tag, "dn_mask", DW'(dn_mask), DW'(e_dm));
        cmp(tag, "dn_seq", DW'(dn_seq), DW'(e_ds));
        cmp(tag, "load_done", DW'(load_done), DW'(e_ld));
        cmp(tag, "load_data", load_data, e_ldd);
        cmp(tag, "store_done", DW'(store_done), DW'(e_st));
        cmp(tag, "atomic_done", DW'(atomic_done), DW'(e_at));
        cmp(tag, "atomic_data", atomic_data, e_atd);
        cmp(tag, "atomic_seq", DW'(atomic_seq), DW'(e_ats));
        cmp(tag, "write_done", DW'(write_done), DW'(e_wd));
        cmp(tag, "write_seq", DW'(write_seq), DW'(e_ws));
        cmp(tag, "flush_flag", DW'(flush_flag), DW'(e_fl));
    endtask

    task automatic step(string tag, bit rv, int op, logic [DW-1:0] d,
                        logic [NB-1:0] mk, logic [SW-1:0] sq,
                        bit pv, int rt, logic [DW-1:0] rd, logic [SW-1:0] rs);
        bit ready;
        bit fire;
        int nst;
        logic [DW-1:0] ndata;
        logic [NB-1:0] nmask;
        @(negedge clk);
        compare_all(prev_tag);
        req_valid = rv;  req_op = 3'(op); req_data = d; req_mask = mk; req_seq = sq;
        rsp_valid = pv;  rsp_type = 2'(rt); rsp_data = rd; rsp_seq = rs;
        #1;
        ready = !(pv && (rt == 0 || rt == 1)) && !(m_st == 2 && op <= 2);
        cmp(tag, "req_ready", DW'(req_ready), DW'(ready));
        {e_dnv, e_ld, e_st, e_at, e_wd, e_fl} = '0;
        e_dop = 0; e_dd = 0; e_ldd = 0; e_atd = 0; e_dm = 0; e_ds = 0; e_ats = 0; e_ws = 0;
        nst = m_st; ndata = m_data; nmask = m_mask;
        if (pv) begin
            if (rt == 0 && m_st != 2) begin
                for (int b = 0; b < NB; b++)
                    if (!m_mask[b]) ndata[b*8 +: 8] = rd[b*8 +: 8];
                nmask = '0; nst = 1; e_ld = 1; e_ldd = ndata;
            end else if (rt == 1 && m_st == 2) begin
                ndata = rd; nmask = '0; nst = 0;
                e_at = 1; e_atd = rd; e_ats = m_tbe;
            end else if (rt == 2) begin
                e_wd = 1; e_ws = rs;
            end
        end
        fire = rv && ready;
        if (fire) begin
            case (op)
                0: if (m_st == 1) begin e_ld = 1; e_ldd = m_data; end
                   else begin e_dnv = 1; e_dop = 2'd1; e_ds = sq; end
                1: begin
                    for (int b = 0; b < NB; b++)
                        if (mk[b]) ndata[b*8 +: 8] = d[b*8 +: 8];
                    nmask = m_mask | mk; e_st = 1;
                    e_dnv = 1; e_dop = 2'd2; e_dd = d; e_dm = mk; e_ds = sq;
                    if (m_st == 1) nst = 0;
                end
                2: begin
                    e_dnv = 1; e_dop = 2'd3; e_dd = d; e_dm = mk; e_ds = sq;
                    nst = 2; m_tbe = sq;
                end
                3: e_fl = 1;
                4: if (m_st != 2) begin nst = 0; nmask = '0; end
                default: ;
            endcase
        end
        m_st = nst; m_data = ndata; m_mask = nmask;
        prev_tag = tag;
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, '0, '0, '0, 0, 0, '0, '0);
    endtask

    function automatic logic [DW-1:0] pat(input logic [7:0] k);
        logic [DW-1:0] v;
        for (int b = 0; b < NB; b++) v[b*8 +: 8] = k ^ 8'(b);
        return v;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_err++;
            $display("FAIL R1 watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state, idle outputs
        idle("R1");
        idle("R1");
        // R2: load to invalid line issues read-block
        step("R2", 1, 0, '0, '0, 16'h0011, 0, 0, '0, '0);
        // R3: fill makes line valid and returns data
        step("R3", 0, 0, '0, '0, '0, 1, 0, pat(8'hA0), '0);
        // R2: load hit
        step("R2", 1, 0, '0, '0, 16'h0012, 0, 0, '0, '0);
        // R5: store to valid line writes through and invalidates
        step("R5", 1, 1, pat(8'h5C), 64'h0000_0000_0000_00F0, 16'h0021, 0, 0, '0, '0);
        step("R5", 1, 0, '0, '0, 16'h0022, 0, 0, '0, '0);
        // R3: fill keeps the bytes stored earlier
        step("R3", 0, 0, '0, '0, '0, 1, 0, pat(8'h33), '0);
        idle("R3");
        // R4: two stores to invalid line accumulate the mask
        step("R10", 1, 4, '0, '0, '0, 0, 0, '0, '0);
        step("R4", 1, 1, pat(8'h71), 64'h8000_0000_0000_0001, 16'h0031, 0, 0, '0, '0);
        step("R4", 1, 1, pat(8'h92), 64'h0000_00FF_0000_0000, 16'h0032, 0, 0, '0, '0);
        step("R11", 0, 0, '0, '0, '0, 1, 2, '0, 16'h0031);
        step("R3", 0, 0, '0, '0, '0, 1, 0, pat(8'hC4), '0);
        step("R2", 1, 0, '0, '0, 16'h0033, 0, 0, '0, '0);
        // R6: atomic from valid line
        step("R6", 1, 2, pat(8'h0F), 64'h0000_0000_0000_000F, 16'h0041, 0, 0, '0, '0);
        // R7: load, store and atomic held while atomic pending
        step("R7", 1, 0, '0, '0, 16'h0042, 0, 0, '0, '0);
        step("R7", 1, 1, pat(8'h10), 64'hFFFF, 16'h0043, 0, 0, '0, '0);
        step("R7", 1, 2, pat(8'h11), 64'hFF, 16'h0044, 0, 0, '0, '0);
        // R9: flush accepted while pending
        step("R9", 1, 3, '0, '0, '0, 0, 0, '0, '0);
        // R10: evict while pending has no effect
        step("R10", 1, 4, '0, '0, '0, 0, 0, '0, '0);
        // R11: write ack while pending, with a held load
        step("R11", 1, 0, '0, '0, 16'h0042, 1, 2, '0, 16'h0032);
        // R8: atomic result returns, held load still blocked (R12)
        step("R8", 1, 0, '0, '0, 16'h0042, 1, 1, pat(8'hE7), '0);
        step("R8", 1, 0, '0, '0, 16'h0042, 0, 0, '0, '0);
        // R8: atomic result outside atomic-pending ignored
        step("R8", 0, 0, '0, '0, '0, 1, 1, pat(8'h66), '0);
        // R13: unused request and response codes
        step("R13", 1, 5, pat(8'h44), 64'hFFFF_FFFF, 16'h0051, 0, 0, '0, '0);
        step("R13", 1, 7, pat(8'h45), 64'hFF, 16'h0052, 1, 3, pat(8'h99), 16'h0053);
        // R12: fill with simultaneous load is blocked
        step("R12", 1, 0, '0, '0, 16'h0061, 1, 0, pat(8'h2B), '0);
        step("R12", 1, 0, '0, '0, 16'h0061, 0, 0, '0, '0);
        // R9: flush in valid state keeps line valid
        step("R9", 1, 3, '0, '0, '0, 0, 0, '0, '0);
        step("R9", 1, 0, '0, '0, 16'h0062, 0, 0, '0, '0);
        // R11: write ack alongside a store
        step("R11", 1, 1, pat(8'h3D), 64'h0F00, 16'h0071, 1, 2, '0, 16'h0070);
        // R10: evict clears mask, so the fill replaces every byte
        step("R10", 1, 4, '0, '0, '0, 0, 0, '0, '0);
        step("R10", 1, 0, '0, '0, 16'h0072, 0, 0, '0, '0);
        step("R10", 0, 0, '0, '0, '0, 1, 0, pat(8'h5A), '0);
        // R6: atomic from invalid line
        step("R10", 1, 4, '0, '0, '0, 0, 0, '0, '0);
        step("R6", 1, 2, pat(8'h7E), 64'hF0, 16'h0081, 0, 0, '0, '0);
        step("R8", 0, 0, '0, '0, '0, 1, 1, pat(8'h81), '0);
        idle("R8");
        idle("R1");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule